// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 interrupt request lines into a single status register and presents them to a processor as two outputs: a normal request and a critical request. Each line can be set as edge type or level type. An edge-type line latches on a rising input and holds until software clears it. A level-type line tracks its input. An enable mask gates the pending bits. A per-bit critical-select register then decides which of the two outputs each enabled request drives.

For the critical path, the block also forms a vector. The vector is a software-chosen base address plus 512 times the priority index of the winning critical request. A configuration bit sets whether priority is scanned from the least significant status bit upward or from the most significant bit downward.

Software reaches the block through a simple register port. The port has a 4-bit word offset, one-cycle write and read strobes, and 32-bit write and read data. Reads are combinational on the offset. Both interrupt outputs and the vector are registered.

Top module: `irqc_top`

## Requirements
- R1: Input line n (irqIn[n]) maps to register bit 31−n, so line 0 is status bit 31. A read at offset 0 and a read at offset 1 both return the raw status.
- R2: When the trigger bit at offset 5 is 1, a rising input sets the status bit on the capturing clock edge. The bit then stays set after the input falls. It clears only when software writes a 1 to that bit at offset 0.
- R3: When the trigger bit is 0, the status bit takes the new input level whenever the input changes. A write to offset 0 first clears each bit written as 1. It then sets again every level-type bit whose input is still high.
- R4: A write to offset 1 ORs the written value into status. For a level-type bit, this set persists until its input changes or the bit is cleared.
- R5: Offset 2 holds the enable mask and reads back as written. Offset 6 reads status AND enable. Writes to offset 6 are ignored.
- R6: irqNormOut is high one clock after (status AND enable AND NOT critical) is nonzero, and low one clock after it is zero.
- R7: Offset 3 holds the critical select and reads back as written. irqCritOut is high one clock after (status AND enable AND critical) is nonzero, and low one clock after it is zero.
- R8: While a critical request is pending, offset 7 reads (configuration AND NOT 3) + 512 × idx, one clock after the request appears. With configuration bit 0 equal to 0, idx is the lowest set critical status bit number. With configuration bit 0 equal to 1, idx is 31 minus the highest set bit number.
- R9: Writes to offset 8 store the value with bit 1 forced to 0. Offset 7 reads zero when no critical request is pending. Writes to offset 7 are ignored.
- R10: Offset 4 (polarity) and offset 5 (trigger) read back as written. The polarity register has no effect on status.
- R11: Offsets 9 to 15 read as zero, and writes to them change no register.
- R12: Reset clears status, enable, critical, polarity, trigger, vector configuration, vector and both outputs. A read returns zero while regRd is low.
- R13: With VECTOR_EN = 0, offsets 7 and 8 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 32 | Request lines, line n at bit n |
| regAddr | input | 4 | Register word offset |
| regWr | input | 1 | Write strobe, one cycle per write |
| regRd | input | 1 | Read enable for rdData |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data |
| irqNormOut | output | 1 | Registered normal interrupt request |
| irqCritOut | output | 1 | Registered critical interrupt request |

## Verification
Some properties are checked on every cycle by assertions. Each output must follow, one clock later, whether any enabled non-critical or critical request is pending. A latched edge-type status bit must never drop without a clear write. The vector must be zero whenever the critical output is low.

Other behaviour only the bench scenarios can show. These include the line-to-bit reversal and the clear-then-reassert rule for level lines. They also cover the exact vector arithmetic for every line in both scan directions, the winner among several pending critical requests, and that ignored offsets and the polarity register leave status untouched.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int OFF_W = 4;

  localparam logic [OFF_W-1:0] OFF_STAT   = 4'd0;
  localparam logic [OFF_W-1:0] OFF_SET    = 4'd1;
  localparam logic [OFF_W-1:0] OFF_EN     = 4'd2;
  localparam logic [OFF_W-1:0] OFF_CRIT   = 4'd3;
  localparam logic [OFF_W-1:0] OFF_POL    = 4'd4;
  localparam logic [OFF_W-1:0] OFF_TRIG   = 4'd5;
  localparam logic [OFF_W-1:0] OFF_MASKED = 4'd6;
  localparam logic [OFF_W-1:0] OFF_VEC    = 4'd7;
  localparam logic [OFF_W-1:0] OFF_VCFG   = 4'd8;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic             wrClr;
    logic             wrSet;
    logic             wrEn;
    logic             wrCrit;
    logic             wrPol;
    logic             wrTrig;
    logic             wrCfg;
    logic             rdEn;
    logic [OFF_W-1:0] rdSel;
  } ctrlStrb_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic [OFF_W-1:0] regAddr,
  input  logic             regWr,
  input  logic             regRd,
  output ctrlStrb_t        strb
);
  always_comb begin
    strb        = '0;
    strb.rdEn   = regRd;
    strb.rdSel  = regAddr;
    if (regWr) begin
      case (regAddr)
        OFF_STAT: strb.wrClr  = 1'b1;
        OFF_SET:  strb.wrSet  = 1'b1;
        OFF_EN:   strb.wrEn   = 1'b1;
        OFF_CRIT: strb.wrCrit = 1'b1;
        OFF_POL:  strb.wrPol  = 1'b1;
        OFF_TRIG: strb.wrTrig = 1'b1;
        OFF_VCFG: strb.wrCfg  = 1'b1;
        default:  ;  // masked-status, vector and unmapped offsets take no write
      endcase
    end
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int W     = 32,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     reqVec,
  input  logic             scanDown,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  logic [W-1:0] revVec;
  logic [W-1:0] scanVec;

  // reversing the request vector lets one lowest-first encoder serve both directions
  for (genvar g = 0; g < W; g++) begin : g_rev
    assign revVec[g] = reqVec[W-1-g];
  end

  assign scanVec = scanDown ? revVec : reqVec;
  assign hit     = |scanVec;

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (scanVec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter bit VECTOR_EN = 1'b1,
  parameter int VEC_SHIFT = 9,
  localparam int IDX_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] irqIn,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqNormOut,
  output logic              irqCritOut
);
  logic [DATA_W-1:0] lineBits, linePrev;
  logic [DATA_W-1:0] statusQ, statusD;
  logic [DATA_W-1:0] enQ, critQ, polQ, trigQ;
  logic [DATA_W-1:0] cfgQ, vecQ;
  logic [DATA_W-1:0] riseBits, chgBits, levelChg;
  logic [DATA_W-1:0] maskedBits, critVec;
  logic              normPend;
  logic              critHit;
  logic [IDX_W-1:0]  critIdx;
  logic [DATA_W-1:0] vecD;

  // line n lands on register bit DATA_W-1-n
  for (genvar g = 0; g < DATA_W; g++) begin : g_map
    assign lineBits[DATA_W-1-g] = irqIn[g];
  end

  assign riseBits = lineBits & ~linePrev;
  assign chgBits  = lineBits ^ linePrev;
  assign levelChg = chgBits & ~trigQ;

  always_comb begin
    statusD = statusQ;
    if (strb.wrClr) statusD = (statusD & ~wrData) | (lineBits & ~trigQ);
    if (strb.wrSet) statusD = statusD | wrData;
    statusD = statusD | (riseBits & trigQ);
    statusD = (statusD & ~levelChg) | (levelChg & lineBits);
  end

  assign maskedBits = statusQ & enQ;
  assign normPend   = |(maskedBits & ~critQ);
  assign critVec    = maskedBits & critQ;

  irqc_prio #(.W(DATA_W)) u_prio (
    .reqVec   (critVec),
    .scanDown (cfgQ[0]),
    .hit      (critHit),
    .idx      (critIdx)
  );

  always_comb begin
    vecD = '0;
    if (critHit)
      vecD = {cfgQ[DATA_W-1:2], 2'b00} + (DATA_W'(critIdx) << VEC_SHIFT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ    <= '0;
      enQ        <= '0;
      critQ      <= '0;
      polQ       <= '0;
      trigQ      <= '0;
      linePrev   <= '0;
      irqNormOut <= 1'b0;
      irqCritOut <= 1'b0;
    end else begin
      statusQ    <= statusD;
      linePrev   <= lineBits;
      irqNormOut <= normPend;
      irqCritOut <= |critVec;
      if (strb.wrEn)   enQ   <= wrData;
      if (strb.wrCrit) critQ <= wrData;
      if (strb.wrPol)  polQ  <= wrData;
      if (strb.wrTrig) trigQ <= wrData;
    end
  end

  if (VECTOR_EN) begin : g_vec
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgQ <= '0;
        vecQ <= '0;
      end else begin
        vecQ <= vecD;
        if (strb.wrCfg) cfgQ <= wrData & ~DATA_W'(2);
      end
    end

    p_vec_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
      !irqCritOut |-> (vecQ == '0));
  end else begin : g_novec
    assign cfgQ = '0;
    assign vecQ = '0;
  end

  always_comb begin
    rdData = '0;
    if (strb.rdEn) begin
      case (strb.rdSel)
        OFF_STAT, OFF_SET: rdData = statusQ;
        OFF_EN:            rdData = enQ;
        OFF_CRIT:          rdData = critQ;
        OFF_POL:           rdData = polQ;
        OFF_TRIG:          rdData = trigQ;
        OFF_MASKED:        rdData = maskedBits;
        OFF_VEC:           rdData = vecQ;
        OFF_VCFG:          rdData = cfgQ;
        default:           rdData = '0;
      endcase
    end
  end

  p_norm_on_r6: assert property (@(posedge clk) disable iff (!rstN)
    normPend |=> irqNormOut);
  p_norm_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    !normPend |=> !irqNormOut);
  p_crit_on_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|critVec) |=> irqCritOut);
  p_crit_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(|critVec) |=> !irqCritOut);
  p_edge_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrClr && !strb.wrTrig) |=>
      ((statusQ & $past(statusQ & trigQ)) == $past(statusQ & trigQ)));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter bit VECTOR_EN = 1'b1,
  parameter int VEC_SHIFT = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] irqIn,
  input  logic [OFF_W-1:0]  regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqNormOut,
  output logic              irqCritOut
);
  ctrlStrb_t strb;

  irqc_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWr   (regWr),
    .regRd   (regRd),
    .strb    (strb)
  );

  irqc_datapath #(
    .DATA_W    (DATA_W),
    .VECTOR_EN (VECTOR_EN),
    .VEC_SHIFT (VEC_SHIFT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .irqIn      (irqIn),
    .strb       (strb),
    .wrData     (wrData),
    .rdData     (rdData),
    .irqNormOut (irqNormOut),
    .irqCritOut (irqCritOut)
  );
endmodule

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqIn = '0;
  logic [3:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, rdData2;
  logic        irqNormOut, irqCritOut, irqNormOut2, irqCritOut2;

  int checks = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  irqc_top u_irqc_top (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regAddr(regAddr), .regWr(regWr),
    .regRd(regRd), .wrData(wrData), .rdData(rdData),
    .irqNormOut(irqNormOut), .irqCritOut(irqCritOut)
  );

  irqc_top #(.VECTOR_EN(1'b0)) u_irqc_top_novec (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regAddr(regAddr), .regWr(regWr),
    .regRd(regRd), .wrData(wrData), .rdData(rdData2),
    .irqNormOut(irqNormOut2), .irqCritOut(irqCritOut2)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [31:0] v, output logic [31:0] v2);
    regAddr = a; regRd = 1'b1;
    #1;
    v = rdData; v2 = rdData2;
    regRd = 1'b0;
  endtask

  task automatic setLine(input int n, input logic val);
    @(negedge clk);
    irqIn[n] = val;
    @(negedge clk);
  endtask

  function automatic logic [31:0] vecExp(input logic [31:0] cfg, input int n, input bit dir);
    int idx;
    idx = dir ? n : 31 - n;
    return (cfg & ~32'd3) + (32'(idx) << 9);
  endfunction

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R12: reset state of every register and both outputs
    for (int a = 0; a < 9; a++) begin
      rdReg(4'(a), v, v2);
      chk("R12 reset register", v, 32'h0);
    end
    chk("R12 reset normal out", 32'(irqNormOut), 32'h0);
    chk("R12 reset critical out", 32'(irqCritOut), 32'h0);
    regAddr = 4'd2; #1;
    chk("R12 read without regRd", rdData, 32'h0);

    // R5, R7, R10: plain storage registers read back
    wrReg(4'd2, 32'hA5A5_0F0F); rdReg(4'd2, v, v2); chk("R5 enable readback", v, 32'hA5A5_0F0F);
    wrReg(4'd3, 32'h1234_8765); rdReg(4'd3, v, v2); chk("R7 critical readback", v, 32'h1234_8765);
    wrReg(4'd4, 32'hDEAD_BEEF); rdReg(4'd4, v, v2); chk("R10 polarity readback", v, 32'hDEAD_BEEF);
    wrReg(4'd5, 32'h0F0F_F0F0); rdReg(4'd5, v, v2); chk("R10 trigger readback", v, 32'h0F0F_F0F0);
    wrReg(4'd2, 32'h0); wrReg(4'd3, 32'h0);

    // R1, R2: every line as edge type
    wrReg(4'd5, 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n++) begin
      setLine(n, 1'b1);
      rdReg(4'd0, v, v2); chk("R1 edge set at bit 31-n", v, 32'h1 << (31 - n));
      rdReg(4'd1, v, v2); chk("R1 status via set offset", v, 32'h1 << (31 - n));
      setLine(n, 1'b0);
      rdReg(4'd0, v, v2); chk("R2 edge bit sticky", v, 32'h1 << (31 - n));
      wrReg(4'd0, 32'h1 << (31 - n));
      rdReg(4'd0, v, v2); chk("R2 edge bit cleared", v, 32'h0);
    end

    // R3, R4: level type
    wrReg(4'd5, 32'h0);
    setLine(3, 1'b1);
    rdReg(4'd0, v, v2); chk("R3 level follows high", v, 32'h1000_0000);
    wrReg(4'd0, 32'h1000_0000);
    rdReg(4'd0, v, v2); chk("R3 clear reasserts high level", v, 32'h1000_0000);
    setLine(3, 1'b0);
    rdReg(4'd0, v, v2); chk("R3 level follows low", v, 32'h0);
    wrReg(4'd1, 32'h1000_0000);
    repeat (3) tick();
    rdReg(4'd0, v, v2); chk("R4 set persists on quiet level", v, 32'h1000_0000);
    wrReg(4'd1, 32'h0000_00F0);
    rdReg(4'd0, v, v2); chk("R4 set ORs in", v, 32'h1000_00F0);
    wrReg(4'd0, 32'hFFFF_FFFF);
    rdReg(4'd0, v, v2); chk("R3 clear all", v, 32'h0);

    // R10: polarity has no effect on status
    setLine(7, 1'b1);
    wrReg(4'd4, 32'hFFFF_FFFF);
    tick();
    rdReg(4'd0, v, v2); chk("R10 polarity ignored", v, 32'h0100_0000);
    setLine(7, 1'b0);
    wrReg(4'd4, 32'h0);

    // R5: masked status, write to offset 6 ignored
    wrReg(4'd1, 32'hF0F0_0000);
    wrReg(4'd2, 32'hFF00_FF00);
    rdReg(4'd6, v, v2); chk("R5 masked status", v, 32'hF000_0000);
    wrReg(4'd6, 32'hFFFF_FFFF);
    rdReg(4'd6, v, v2); chk("R5 masked write ignored", v, 32'hF000_0000);
    rdReg(4'd0, v, v2); chk("R5 status after masked write", v, 32'hF0F0_0000);
    rdReg(4'd2, v, v2); chk("R5 enable after masked write", v, 32'hFF00_FF00);
    wrReg(4'd0, 32'hFFFF_FFFF);
    wrReg(4'd2, 32'h0);
    tick();

    // R6, R7: outputs one clock after the registers
    wrReg(4'd2, 32'hFFFF_FFFF);
    wrReg(4'd1, 32'h0000_0100);
    chk("R6 normal not yet", 32'(irqNormOut), 32'h0);
    tick();
    chk("R6 normal raised", 32'(irqNormOut), 32'h1);
    chk("R7 critical still low", 32'(irqCritOut), 32'h0);
    wrReg(4'd3, 32'h0000_0100);
    chk("R7 critical not yet", 32'(irqCritOut), 32'h0);
    tick();
    chk("R7 critical raised", 32'(irqCritOut), 32'h1);
    chk("R6 normal dropped", 32'(irqNormOut), 32'h0);
    wrReg(4'd2, 32'h0);
    tick();
    chk("R7 critical dropped by enable", 32'(irqCritOut), 32'h0);
    wrReg(4'd0, 32'hFFFF_FFFF);

    // R8, R9: vector sweep over every line and both directions
    wrReg(4'd5, 32'hFFFF_FFFF);
    wrReg(4'd2, 32'hFFFF_FFFF);
    wrReg(4'd3, 32'hFFFF_FFFF);
    for (int d = 0; d < 2; d++) begin
      wrReg(4'd8, 32'h0004_0002 | 32'(d));
      rdReg(4'd8, v, v2); chk("R9 config bit1 forced low", v, 32'h0004_0000 | 32'(d));
      for (int n = 0; n < 32; n++) begin
        wrReg(4'd1, 32'h1 << (31 - n));
        tick();
        rdReg(4'd7, v, v2);
        chk("R8 vector single request", v, vecExp(32'h0004_0000, n, d[0]));
        wrReg(4'd0, 32'hFFFF_FFFF);
        tick();
        rdReg(4'd7, v, v2); chk("R9 vector zero when idle", v, 32'h0);
      end
    end

    // R8: two pending, lines 5 and 20 (bits 26 and 11)
    wrReg(4'd8, 32'h0010_0003);
    wrReg(4'd1, 32'h0400_0800);
    tick();
    rdReg(4'd7, v, v2); chk("R8 downward scan winner", v, 32'h0010_0000 + (32'd5 << 9));
    chk("R13 novec reads vector zero", v2, 32'h0);
    rdReg(4'd8, v, v2);
    chk("R13 novec reads config zero", v2, 32'h0);
    chk("R13 novec critical out", 32'(irqCritOut2), 32'h1);
    wrReg(4'd8, 32'h0010_0000);
    tick();
    rdReg(4'd7, v, v2); chk("R8 upward scan winner", v, 32'h0010_0000 + (32'd11 << 9));
    wrReg(4'd7, 32'hFFFF_FFFF);
    tick();
    rdReg(4'd7, v, v2); chk("R9 vector write ignored", v, 32'h0010_0000 + (32'd11 << 9));

    // R11: unmapped offsets
    for (int a = 9; a < 16; a++) begin
      wrReg(4'(a), 32'hFFFF_FFFF);
      rdReg(4'(a), v, v2); chk("R11 unmapped reads zero", v, 32'h0);
    end
    rdReg(4'd0, v, v2); chk("R11 status untouched", v, 32'h0400_0800);
    rdReg(4'd3, v, v2); chk("R11 critical untouched", v, 32'hFFFF_FFFF);
    rdReg(4'd8, v, v2); chk("R11 config untouched", v, 32'h0010_0000);

    // R12: mid-run reset
    @(negedge clk); rstN = 1'b0;
    tick(); tick();
    rstN = 1'b1;
    for (int a = 0; a < 9; a++) begin
      rdReg(4'(a), v, v2);
      chk("R12 reset clears register", v, 32'h0);
    end
    chk("R12 reset clears critical out", 32'(irqCritOut), 32'h0);

    finishRun();
  end
endmodule